// File: doc/BRIEF.md
# Prescaled Compare Timer

This block is an up-counter, `CNT_W` bits wide by default 32, that advances on a qualified tick. A tick enters on `tick_in` and passes through two dividers. The first is an optional pre-divider, active only when `osc_sel` is high. The second is the main prescaler. Each pulse that leaves the main prescaler advances the counter by one.

The counter can run in two ways. In free-run mode it wraps from its maximum value to zero. In restart mode it goes back to zero on the tick that follows a match on compare channel 0.

There are `NCH` compare channels, three by default. Each channel watches for the counter arriving at its compare value. When that happens it pulses an event and applies its configured action to its own output pin. A force strobe applies the same action without waiting for a match. Configuration reaches the block as plain register-style inputs, and all outputs are registered.

Top module: `cmp_timer`

## Requirements
- R1: With `osc_sel` low, `count` advances by one every (`presc`+1) cycles in which `tick_in` is high while the timer runs. `presc` is a 12-bit field, so the ratio is 1 to 4096. The timer runs in the cycles where `en` is high and `en` was also high in the cycle before.
- R2: With `osc_sel` high, an extra divide by (`osc_div`+1) is placed ahead of the prescaler. `osc_div` is a 4-bit field, so this ratio is 1 to 16. While `osc_sel` is low, `osc_div` has no effect on counting.
- R3: Both divider counters return to zero while the timer is not running. A divider counter also returns to zero in any cycle where its ratio input differs from its value in the previous cycle, and that cycle produces no tick from that divider.
- R4: While `en` is low, `count` holds its value and no compare or rollover event occurs.
- R5: On the cycle where `en` rises, `count` loads 0 if `clr_on_en` is 1. If `clr_on_en` is 0, `count` keeps its value.
- R6: When a tick arrives with `count` at its maximum, `count` becomes 0. In the same cycle `roll_evt` pulses for one cycle.
- R7: With `free_run` low, the tick taken while `count` equals channel 0's compare value loads 0. This reload takes priority over the wrap, and it raises no rollover event.
- R8: `cmp_evt[i]` is high for exactly the cycles in which `count` has just taken, on a tick, a value equal to the compare value of channel `i`. The compare value of channel `i` sits in bits `[i*CNT_W +: CNT_W]` of `cmp_val`. Holding the count does not repeat the event.
- R9: Channel `i`'s mode sits in `cmp_mode[3*i +: 3]`. Code 0 leaves the pin unchanged, 1 toggles it, 2 drives it low and 3 drives it high. Codes 5 to 7 behave like 0. The pin changes in the same cycle as `cmp_evt[i]`.
- R10: Mode 4 drives the pin low when the channel triggers. The pin goes high again on the next prescaled tick.
- R11: A high `force_stb[i]` applies channel `i`'s configured action at the next clock edge, whatever the comparator result and whether or not the timer runs. It raises no `cmp_evt`.
- R12: Synchronous active-high `rst` clears `count`, `cmp_pin`, `cmp_evt` and `roll_evt` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Selected source tick enable |
| en | input | 1 | Timer enable |
| clr_on_en | input | 1 | Load zero when enable rises |
| free_run | input | 1 | 1 = free-run, 0 = restart on channel 0 match |
| osc_sel | input | 1 | Insert the pre-divider |
| osc_div | input | OSC_W | Pre-divide ratio minus one |
| presc | input | PRE_W | Prescale ratio minus one |
| cmp_val | input | NCH*CNT_W | Packed compare values |
| cmp_mode | input | NCH*3 | Packed pin action codes |
| force_stb | input | NCH | Force the pin action per channel |
| count | output | CNT_W | Counter value |
| cmp_pin | output | NCH | Compare output pins |
| cmp_evt | output | NCH | Compare event pulses |
| roll_evt | output | 1 | Rollover pulse |

## Verification
The bench builds the block with `CNT_W` set to 8, which makes a wrap reachable in a few hundred cycles. `PRE_W`, `OSC_W` and `NCH` keep their default values. With the narrow counter, rollover and the clash between a restart reload and the maximum value both fall inside a short run.

The prescaler and pre-divider ratios are kept small, so that each tick pattern completes many divided periods. A pseudo-random `tick_in` pattern then drives the dividers through irregular gaps.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam int MODE_W = 3;
  typedef enum logic [MODE_W-1:0] {
    PA_NONE   = 3'd0,
    PA_TOGGLE = 3'd1,
    PA_LOW    = 3'd2,
    PA_HIGH   = 3'd3,
    PA_PULSE  = 3'd4
  } pin_act_e;
endpackage

// File: rtl/tk_div.sv
`timescale 1ns/1ps
// Tick divider: passes one in (ratio+1) input ticks, restarts on idle or ratio change.
module tk_div #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         bypass,
  input  logic         in_tick,
  input  logic [W-1:0] ratio,
  output logic         out_tick
);
  logic [W-1:0] cnt_q, ratio_q;
  logic         chg;

  assign chg      = (ratio != ratio_q);
  assign out_tick = run && in_tick && (bypass || (!chg && cnt_q == ratio));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      ratio_q <= '0;
    end else begin
      ratio_q <= ratio;
      if (!run || chg)
        cnt_q <= '0;
      else if (in_tick && !bypass)
        cnt_q <= (cnt_q == ratio) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tk_count.sv
`timescale 1ns/1ps
// Main counter with free-run / restart and clear-on-enable.
module tk_count #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         clr_on_en,
  input  logic         free_run,
  input  logic         tick,
  input  logic [W-1:0] reload_at,
  output logic         run,
  output logic [W-1:0] nxt,
  output logic [W-1:0] count,
  output logic         roll
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  logic en_q, wrap;

  assign run = en && en_q;

  always_comb begin
    wrap = 1'b0;
    if (!free_run && count == reload_at) begin
      nxt = '0;
    end else if (count == MAXV) begin
      nxt  = '0;
      wrap = 1'b1;
    end else begin
      nxt = count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      count <= '0;
      roll  <= 1'b0;
    end else begin
      en_q <= en;
      roll <= tick && wrap;
      if (en && !en_q && clr_on_en)
        count <= '0;
      else if (tick)
        count <= nxt;
    end
  end
endmodule

// File: rtl/oc_chan.sv
`timescale 1ns/1ps
// One compare channel: event pulse and pin action.
module oc_chan
  import tmr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [W-1:0]      nxt,
  input  logic [W-1:0]      cmp,
  input  logic [MODE_W-1:0] mode,
  input  logic              force_stb,
  output logic              evt,
  output logic              pin
);
  logic hit, trig, pul_q;

  assign hit  = tick && (nxt == cmp);
  assign trig = hit || force_stb;

  always_ff @(posedge clk) begin
    if (rst) begin
      evt   <= 1'b0;
      pin   <= 1'b0;
      pul_q <= 1'b0;
    end else begin
      evt <= hit;
      if (trig && mode == PA_PULSE)
        pul_q <= 1'b1;
      else if (tick)
        pul_q <= 1'b0;
      if (trig) begin
        case (mode)
          PA_TOGGLE: pin <= ~pin;
          PA_LOW:    pin <= 1'b0;
          PA_HIGH:   pin <= 1'b1;
          PA_PULSE:  pin <= 1'b0;
          default:   pin <= pin;
        endcase
      end else if (tick && pul_q) begin
        pin <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmp_timer.sv
`timescale 1ns/1ps
module cmp_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PRE_W = 12,
  parameter int OSC_W = 4,
  parameter int NCH   = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tick_in,
  input  logic                   en,
  input  logic                   clr_on_en,
  input  logic                   free_run,
  input  logic                   osc_sel,
  input  logic [OSC_W-1:0]       osc_div,
  input  logic [PRE_W-1:0]       presc,
  input  logic [NCH*CNT_W-1:0]   cmp_val,
  input  logic [NCH*MODE_W-1:0]  cmp_mode,
  input  logic [NCH-1:0]         force_stb,
  output logic [CNT_W-1:0]       count,
  output logic [NCH-1:0]         cmp_pin,
  output logic [NCH-1:0]         cmp_evt,
  output logic                   roll_evt
);
  logic             run, pre_tick, cnt_tick;
  logic [CNT_W-1:0] nxt;

  tk_div #(.W(OSC_W)) u_prediv (
    .clk(clk), .rst(rst), .run(run), .bypass(!osc_sel),
    .in_tick(tick_in), .ratio(osc_div), .out_tick(pre_tick)
  );

  tk_div #(.W(PRE_W)) u_presc (
    .clk(clk), .rst(rst), .run(run), .bypass(1'b0),
    .in_tick(pre_tick), .ratio(presc), .out_tick(cnt_tick)
  );

  tk_count #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(en), .clr_on_en(clr_on_en),
    .free_run(free_run), .tick(cnt_tick), .reload_at(cmp_val[CNT_W-1:0]),
    .run(run), .nxt(nxt), .count(count), .roll(roll_evt)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    oc_chan #(.W(CNT_W)) u_ch (
      .clk(clk), .rst(rst), .tick(cnt_tick), .nxt(nxt),
      .cmp(cmp_val[i*CNT_W +: CNT_W]),
      .mode(cmp_mode[i*MODE_W +: MODE_W]),
      .force_stb(force_stb[i]),
      .evt(cmp_evt[i]), .pin(cmp_pin[i])
    );
  end
endmodule

// File: rtl/tmr_chk.sv
`timescale 1ns/1ps
module tmr_chk #(
  parameter int CNT_W = 32,
  parameter int PRE_W = 12,
  parameter int OSC_W = 4,
  parameter int NCH   = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 en,
  input logic [CNT_W-1:0]     count,
  input logic                 roll_evt,
  input logic [NCH-1:0]       cmp_evt,
  input logic [NCH-1:0]       cmp_pin,
  input logic [NCH*CNT_W-1:0] cmp_val,
  input logic [NCH*3-1:0]     cmp_mode,
  input logic [NCH-1:0]       force_stb
);
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(en) && !$past(rst)) |-> $stable(count));

  a_r6_roll_zero: assert property (@(posedge clk) disable iff (rst)
    roll_evt |-> (count == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_a
    a_r8_evt_value: assert property (@(posedge clk) disable iff (rst)
      cmp_evt[i] |-> (count == $past(cmp_val[i*CNT_W +: CNT_W])));

    a_r11_force_toggle: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(force_stb[i]) && $past(cmp_mode[i*3 +: 3]) == 3'd1)
        |-> (cmp_pin[i] != $past(cmp_pin[i])));

    a_r10_pulse_low: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(force_stb[i]) && $past(cmp_mode[i*3 +: 3]) == 3'd4)
        |-> !cmp_pin[i]);
  end
endmodule

bind cmp_timer tmr_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W), .OSC_W(OSC_W), .NCH(NCH)) u_tmr_chk (.*);

// File: tb/test_cmp_timer.sv
`timescale 1ns/1ps
module test_cmp_timer;
  localparam int CW = 8;
  localparam int PW = 12;
  localparam int OW = 4;
  localparam int NC = 3;
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 1'b0, rst = 1'b1, tick_in = 1'b0, en = 1'b0;
  logic clr_on_en = 1'b0, free_run = 1'b1, osc_sel = 1'b0;
  logic [OW-1:0] osc_div = '0;
  logic [PW-1:0] presc = '0;
  logic [NC*CW-1:0] cmp_val = '0;
  logic [NC*3-1:0] cmp_mode = '0;
  logic [NC-1:0] force_stb = '0;
  logic [CW-1:0] count;
  logic [NC-1:0] cmp_pin, cmp_evt;
  logic roll_evt;

  cmp_timer #(.CNT_W(CW), .PRE_W(PW), .OSC_W(OW), .NCH(NC)) i_cmp_timer (
    .clk(clk), .rst(rst), .tick_in(tick_in), .en(en), .clr_on_en(clr_on_en),
    .free_run(free_run), .osc_sel(osc_sel), .osc_div(osc_div), .presc(presc),
    .cmp_val(cmp_val), .cmp_mode(cmp_mode), .force_stb(force_stb),
    .count(count), .cmp_pin(cmp_pin), .cmp_evt(cmp_evt), .roll_evt(roll_evt)
  );

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  string req = "R12";
  logic [15:0] lf = 16'hACE1;
  bit use_lf = 1'b0;

  // behavioural reference
  int m_cnt = 0, m_pd = 0, m_ps = 0, m_odq = 0, m_psq = 0;
  bit m_enq = 0, m_roll = 0;
  bit m_evt [NC];
  bit m_pin [NC];
  bit m_pul [NC];

  always @(posedge clk) begin
    bit run, t1, t2, c1, c2, wrap, trig;
    int nxt, cv, md;
    if (rst) begin
      m_cnt = 0; m_pd = 0; m_ps = 0; m_odq = 0; m_psq = 0; m_enq = 0; m_roll = 0;
      for (int i = 0; i < NC; i++) begin m_evt[i] = 0; m_pin[i] = 0; m_pul[i] = 0; end
    end else begin
      run = en && m_enq;
      c1 = (int'(osc_div) != m_odq);
      t1 = run && tick_in && (!osc_sel || (!c1 && m_pd == int'(osc_div)));
      if (!run || c1) m_pd = 0;
      else if (tick_in && osc_sel) m_pd = (m_pd == int'(osc_div)) ? 0 : m_pd + 1;
      c2 = (int'(presc) != m_psq);
      t2 = run && t1 && !c2 && m_ps == int'(presc);
      if (!run || c2) m_ps = 0;
      else if (t1) m_ps = (m_ps == int'(presc)) ? 0 : m_ps + 1;
      wrap = 0;
      if (!free_run && m_cnt == int'(cmp_val[CW-1:0])) nxt = 0;
      else if (m_cnt == MAXV) begin nxt = 0; wrap = 1; end
      else nxt = m_cnt + 1;
      m_roll = t2 && wrap;
      for (int i = 0; i < NC; i++) begin
        cv = int'(cmp_val[i*CW +: CW]);
        md = int'(cmp_mode[i*3 +: 3]);
        m_evt[i] = t2 && nxt == cv;
        trig = m_evt[i] || force_stb[i];
        if (trig) begin
          case (md)
            1: m_pin[i] = !m_pin[i];
            2: m_pin[i] = 0;
            3: m_pin[i] = 1;
            4: m_pin[i] = 0;
            default: ;
          endcase
        end else if (t2 && m_pul[i]) m_pin[i] = 1;
        if (trig && md == 4) m_pul[i] = 1;
        else if (t2) m_pul[i] = 0;
      end
      if (en && !m_enq && clr_on_en) m_cnt = 0;
      else if (t2) m_cnt = nxt;
      m_enq = en; m_odq = int'(osc_div); m_psq = int'(presc);
    end
  end

  task automatic chk(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst) begin
      // R12 reset state
      chk("reset count", int'(count), 0);
      chk("reset pins", int'(cmp_pin), 0);
      chk("reset evt", int'({cmp_evt, roll_evt}), 0);
    end else begin
      chk("count", int'(count), m_cnt);
      chk("roll", int'(roll_evt), int'(m_roll));
      for (int i = 0; i < NC; i++) begin
        chk($sformatf("evt%0d", i), int'(cmp_evt[i]), int'(m_evt[i]));
        chk($sformatf("pin%0d", i), int'(cmp_pin[i]), int'(m_pin[i]));
      end
    end
    if (use_lf) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      tick_in = lf[0];
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ch(int i, int v, int md);
    cmp_val[i*CW +: CW] = CW'(v);
    cmp_mode[i*3 +: 3] = 3'(md);
  endtask

  task automatic restart0();
    en = 1'b0; cyc(1);
    en = 1'b1; clr_on_en = 1'b1; cyc(1);
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    // R1 basic counting, R9 toggle/high, R10 pulse
    req = "R1/R9/R10";
    set_ch(0, 5, 1); set_ch(1, 10, 3); set_ch(2, 20, 4);
    tick_in = 1'b1; en = 1'b1; clr_on_en = 1'b1; cyc(30);
    // R9 low / none / toggle, R8 single events
    req = "R9/R8";
    set_ch(0, 40, 2); set_ch(1, 45, 0); set_ch(2, 50, 1); cyc(30);
    // R1 with divide by 4, R3 ratio change mid-run
    req = "R1/R3";
    presc = 12'd3; cyc(60);
    presc = 12'd1; cyc(20);
    // R10 pulse lasts one prescaled tick, R8 events with held count
    req = "R10/R8";
    presc = 12'd2; restart0();
    set_ch(0, 3, 4); set_ch(1, 6, 4); set_ch(2, 9, 5); cyc(50);
    // R2 pre-divider with irregular ticks
    req = "R2";
    osc_sel = 1'b1; osc_div = 4'd2; presc = 12'd1; use_lf = 1'b1; cyc(150);
    osc_div = 4'd0; cyc(40);
    // R2 pre-divider ignored when not selected, R3
    req = "R2/R3";
    osc_sel = 1'b0; use_lf = 1'b0; tick_in = 1'b1; presc = 12'd0;
    for (int k = 0; k < 6; k++) begin osc_div = 4'(k * 3); cyc(5); end
    // R4 disabled: hold, no events
    req = "R4";
    set_ch(0, int'(count), 1); set_ch(1, int'(count) + 1, 1);
    en = 1'b0; cyc(20);
    // R5 enable without clear keeps value, with clear loads zero
    req = "R5";
    clr_on_en = 1'b0; en = 1'b1; cyc(10);
    en = 1'b0; cyc(2); clr_on_en = 1'b1; en = 1'b1; cyc(10);
    // R6 wrap and rollover pulse
    req = "R6";
    set_ch(0, 100, 1); set_ch(1, 0, 3); set_ch(2, MAXV, 1); cyc(300);
    // R7 restart on channel 0 match
    req = "R7";
    free_run = 1'b0; set_ch(0, 7, 1); cyc(300);
    set_ch(0, 0, 1); cyc(10);
    set_ch(0, MAXV, 1); restart0(); presc = 12'd0; cyc(280);
    free_run = 1'b1;
    // R11 force strobes while stopped
    req = "R11";
    en = 1'b0; cyc(2);
    for (int md = 0; md < 8; md++) begin
      for (int i = 0; i < NC; i++) set_ch(i, 200, md);
      force_stb = '1; cyc(1); force_stb = '0; cyc(2);
      force_stb = 3'b010; cyc(1); force_stb = '0; cyc(2);
    end
    en = 1'b1; cyc(5);
    // mixed irregular run
    req = "R1/R8/R9/R10";
    set_ch(0, 30, 4); set_ch(1, 60, 1); set_ch(2, 90, 2);
    presc = 12'd1; use_lf = 1'b1; cyc(500);
    use_lf = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL R12 watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule